// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is one general-purpose I/O port of eight bits that sits on a simple register bus. Every bit owns one configuration bit and one data bit. The two bits together place that pin in one of four modes: a floating input, an input with a weak pull-up, a pin that drives zero, or a pin that drives one. The block does not contain the pad. It presents to the pad, per bit, an output-enable, the level to drive and a pull-up enable, and it takes back the raw pin level.

Software reaches three locations through a two-bit address: the configuration register, the data register and a read-only view of the pins. The pin levels pass through a synchronizer before they can be read. A parameter mask names data bits that always read back as zero, for bits that the chip uses for its own purposes. Such bits still control their pins.

Top module: `gpio_port`

## Requirements
- R1: After reset, both registers read as zero and every bit is a floating input: `pin_oe`, `pin_pu` and `pin_out` are all zero.
- R2: A bit whose configuration bit is 0 and data bit is 0 has `pin_oe`=0 and `pin_pu`=0.
- R3: A bit whose configuration bit is 0 and data bit is 1 has `pin_oe`=0 and `pin_pu`=1. The pull-up is never on while the bit drives.
- R4: A bit whose configuration bit is 1 has `pin_oe`=1, `pin_pu`=0 and `pin_out` equal to its data bit. `pin_out` is 0 for every bit that does not drive.
- R5: The mode of each bit depends only on that bit's own configuration and data bits. A mixed pattern gives a mixed set of per-bit modes.
- R6: The address encoding is 0 = configuration, 1 = data, 2 = pin view and 3 = reserved. A write with `bus_wr`=1 takes effect at the next rising clock edge, and the outputs do not change before that edge. `bus_rdata` is combinational from the selected register. Reading address 0 returns the stored configuration.
- R7: Reading address 1 returns the data register with the bits set in `RD_ZERO_MASK` forced to zero (default 8'hC0, bits 7 and 6). Those bits still drive their pins as R4 describes.
- R8: Reading address 2 returns `pin_in` as sampled two rising edges earlier, through a two-stage synchronizer.
- R9: Writes to address 2 or address 3 change neither register. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 configuration, 1 data, 2 pin view, 3 reserved |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_oe | output | 8 | Per-bit output enable |
| pin_out | output | 8 | Per-bit drive level |
| pin_pu | output | 8 | Per-bit weak pull-up enable |

## Verification
The hardest case to bring about is a masked bit. Its data readback is hidden, so a fault in its stored value can only be seen through the pad controls. The stimulus writes random data with random configuration, often with the masked bits set to drive. The masked bits then appear on `pin_out`, and the bench can compare them with the readback that hides them. The synchronizer latency is checked by changing `pin_in` and reading the pin view one edge and two edges later. The one-edge read must still show the old value.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_CFG = 2'd0,
        REG_DAT = 2'd1,
        REG_PIN = 2'd2,
        REG_RSV = 2'd3
    } reg_sel_e;

    // {configuration bit, data bit}
    typedef enum logic [1:0] {
        MODE_HIZ    = 2'b00,
        MODE_PULLUP = 2'b01,
        MODE_DRIVE0 = 2'b10,
        MODE_DRIVE1 = 2'b11
    } pin_mode_e;

    localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned CW = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];

    // Checker state: number of edges since reset, saturating at STAGES
    logic [CW-1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          warm_q <= '0;
        else if (warm_q != CW'(STAGES))      warm_q <= warm_q + 1'b1;
    end

    assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == CW'(STAGES)) |-> (sync_out == $past(async_in, STAGES)));

endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  reg_sel_e         bus_sel,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] cfg_o,
    output logic [WIDTH-1:0] dat_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cfg;
        logic [WIDTH-1:0] dat;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            unique case (bus_sel)
                REG_CFG: st_d.cfg = bus_wdata;
                REG_DAT: st_d.dat = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign dat_o = st_q.dat;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_q.cfg == '0 && st_q.dat == '0));

    assert_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == REG_CFG) |=> (st_q.cfg == $past(bus_wdata)));

    assert_dat_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == REG_DAT) |=> (st_q.dat == $past(bus_wdata)));

    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_sel == REG_CFG || bus_sel == REG_DAT))
        |=> ($stable(st_q.cfg) && $stable(st_q.dat)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cfg_i,
    input  logic [WIDTH-1:0] dat_i,
    output logic [WIDTH-1:0] oe_o,
    output logic [WIDTH-1:0] out_o,
    output logic [WIDTH-1:0] pu_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        pin_mode_e mode;
        assign mode = pin_mode_e'({cfg_i[g], dat_i[g]});

        always_comb begin
            oe_o[g]  = 1'b0;
            out_o[g] = 1'b0;
            pu_o[g]  = 1'b0;
            unique case (mode)
                MODE_HIZ:    ;
                MODE_PULLUP: pu_o[g] = 1'b1;
                MODE_DRIVE0: oe_o[g] = 1'b1;
                MODE_DRIVE1: begin
                    oe_o[g]  = 1'b1;
                    out_o[g] = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned       WIDTH        = 8,
    parameter logic [WIDTH-1:0]  RD_ZERO_MASK = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] cfg_q;
    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] pin_sync;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (sel),
        .bus_wdata (bus_wdata),
        .cfg_o     (cfg_q),
        .dat_o     (dat_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .cfg_i (cfg_q),
        .dat_i (dat_q),
        .oe_o  (pin_oe),
        .out_o (pin_out),
        .pu_o  (pin_pu)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    always_comb begin
        unique case (sel)
            REG_CFG: bus_rdata = cfg_q;
            REG_DAT: bus_rdata = dat_q & ~RD_ZERO_MASK;
            REG_PIN: bus_rdata = pin_sync;
            default: bus_rdata = '0;
        endcase
    end

    assert_pu_not_driving_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    assert_drive_follows_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_DAT) |=> (((pin_out ^ $past(bus_wdata)) & pin_oe) == '0));

    assert_no_drive_when_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

    localparam int        W    = 8;
    localparam logic [7:0] MASK = 8'hC0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_oe, pin_out, pin_pu;

    int tests = 0;
    int fails = 0;

    logic [W-1:0] m_cfg = '0;
    logic [W-1:0] m_dat = '0;

    gpio_port #(.WIDTH(W), .RD_ZERO_MASK(MASK)) u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] f_oe(input logic [W-1:0] c);  return c; endfunction
    function automatic logic [W-1:0] f_out(input logic [W-1:0] c, input logic [W-1:0] d); return c & d; endfunction
    function automatic logic [W-1:0] f_pu(input logic [W-1:0] c, input logic [W-1:0] d); return ~c & d; endfunction
    function automatic logic [W-1:0] f_rd(input logic [W-1:0] d); return d & ~MASK; endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_cfg = d;
        if (a == 2'd1) m_dat = d;
    endtask

    // Called just after a negedge; stays inside the low phase
    task automatic check_all(input string tag);
        chk({tag, " oe"},  pin_oe,  f_oe(m_cfg));
        chk({tag, " out"}, pin_out, f_out(m_cfg, m_dat));
        chk({tag, " pu"},  pin_pu,  f_pu(m_cfg, m_dat));
        bus_addr = 2'd0; #0.5;
        chk({tag, " cfg read"}, bus_rdata, m_cfg);
        bus_addr = 2'd1; #0.5;
        chk({tag, " dat read"}, bus_rdata, f_rd(m_dat));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [W-1:0] r;
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");
        bus_addr = 2'd2; #0.5;
        chk("R1 pin view after reset", bus_rdata, 8'h00);

        // R2: all floating inputs
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        check_all("R2 hiz");
        // R3: all pulled-up inputs
        wr(2'd1, 8'hFF);
        check_all("R3 pullup");
        // R4: all drive one, then all drive zero
        wr(2'd0, 8'hFF);
        check_all("R4 drive1");
        wr(2'd1, 8'h00);
        check_all("R4 drive0");
        // R5: mixed per-bit modes
        wr(2'd0, 8'b1100_1010); wr(2'd1, 8'b1010_0110);
        check_all("R5 mixed");

        // R6: nothing changes before the edge that samples the write
        @(negedge clk);
        bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'h0F;
        #1;
        chk("R6 before edge oe", pin_oe, f_oe(m_cfg));
        @(negedge clk);
        bus_wr = 1'b0; m_cfg = 8'h0F;
        chk("R6 after edge oe", pin_oe, 8'h0F);

        // R7: masked bits driving one, readback hides them
        wr(2'd0, 8'hC0); wr(2'd1, 8'hC3);
        check_all("R7 mask");
        chk("R7 masked drive", pin_out & MASK, 8'hC0);

        // R9: ignored writes to pin view and reserved
        wr(2'd2, 8'h5A); wr(2'd3, 8'hA5);
        check_all("R9 ignored writes");
        bus_addr = 2'd3; #0.5;
        chk("R9 reserved read", bus_rdata, 8'h00);

        // R8: two-edge synchronizer latency
        @(negedge clk);
        pin_in = 8'h00; bus_addr = 2'd2;
        @(negedge clk); @(negedge clk);
        pin_in = 8'h96;
        @(negedge clk);
        chk("R8 one edge", bus_rdata, 8'h00);
        @(negedge clk);
        chk("R8 two edges", bus_rdata, 8'h96);
        for (int k = 0; k < 20; k++) begin
            r = W'($urandom);
            pin_in = r;
            @(negedge clk); @(negedge clk);
            chk("R8 random pin", bus_rdata, r);
        end

        // Random mix across R2..R7 and R9
        for (int k = 0; k < 200; k++) begin
            int unsigned sel;
            sel = $urandom % 4;
            r = W'($urandom);
            if (($urandom % 3) == 0) r = r | MASK;
            wr(2'(sel), r);
            check_all("R5 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule